// File: doc/BRIEF.md
# Flash Status Register Write-Protect Controller

This block keeps the status register of a serial flash device and decides what may be written. The register holds a busy flag, a write-enable latch, a two-bit block-protect level and a write-protect-enable bit. From the protect-enable bit, the level of the hardware write-protect pin and the latch, the block works out two permissions. One says whether the status register itself may be rewritten. The other says whether a given array address lies in a writable block.

The serial front end decodes the commands. It hands this block parallel strobes: set latch, clear latch, status write (with a data byte) and status read. An accepted status write starts a self-timed cycle that lasts a fixed number of clocks. During that cycle only status reads are served, and at its end the latch clears by itself. The memory command engine presents an address and gets back a registered write-permission bit.

Top module: `sr_core`

## Requirements
- R1: After reset the status register reads 0x00, the busy bit is clear, and both permission outputs are 0.
- R2: A set-latch strobe sets status bit 1 and a clear-latch strobe clears it. If strobes arrive together, status write wins over clear-latch, and clear-latch wins over set-latch. An arriving status-write strobe leaves the latch alone.
- R3: A status write is accepted only when the latch is set, the register is writable (R7) and no cycle is running. A rejected write changes nothing.
- R4: An accepted write loads the protect level from data bits 3:2 and the protect-enable bit from data bit 7. Data bits 6:4 and 1:0 are ignored. Status bits 6:4 always read 0.
- R5: An accepted write sets the busy bit (status bit 0) on the next cycle. The bit stays set for exactly WR_CYCLES cycles, and the latch clears on the cycle the bit drops.
- R6: While busy, set-latch, clear-latch and status-write strobes have no effect. A status-read strobe is always answered one cycle later with rd_valid and the status value of the strobe cycle.
- R7: sr_wr_ok is registered. It equals: latch set AND not busy AND (protect-enable = 0 OR wp_pin high).
- R8: With protect-enable = 1 and wp_pin low, status writes are refused, so protect-enable cannot return to 0 until the pin goes high.
- R9: The protect level maps to protected addresses over ADDR_W bits. Level 0 protects nothing. Level 1 protects addresses whose two top bits are 11. Level 2 protects addresses whose top bit is 1. Level 3 protects all addresses.
- R10: addr_wr_ok, one cycle after chk_addr is presented, equals: latch set AND not busy AND address not protected. The pin and protect-enable have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Hardware write-protect pin level (1 = high) |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wr_data | input | 8 | Status-write data byte |
| cmd_rdsr | input | 1 | Status-read strobe |
| chk_addr | input | ADDR_W | Array address to qualify |
| status_o | output | 8 | Live status register |
| rd_valid | output | 1 | Status-read response valid |
| rd_data | output | 8 | Status-read response data |
| sr_wr_ok | output | 1 | Status register currently writable |
| addr_wr_ok | output | 1 | chk_addr writable (one-cycle latency) |

## Verification
The hardest state to reach from the ports is the lock: protect-enable set with the pin low and the latch set. Reaching it needs an enable, then an accepted write with bit 7 set, then a wait for the full timed cycle, then another enable. Only after all that can a write of 0 be tried. The stimulus first walks this path directly, releases the pin to show the lock lifts, and then runs a long stretch of weighted random strobes, pin levels and addresses. During that stretch writes often land mid-cycle or while locked. A behavioural model compares every output on every clock.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef struct packed {
    logic       wpen;
    logic [1:0] level;
    logic       wel;
    logic       busy;
  } sr_state_t;

  function automatic logic [7:0] sr_pack(input sr_state_t s);
    return {s.wpen, 3'b000, s.level, s.wel, s.busy};
  endfunction
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot_o
);
  logic [1:0] top_bits;
  assign top_bits = addr[ADDR_W-1 -: 2];

  always_comb begin
    unique case (level)
      2'd0:    prot_o = 1'b0;
      2'd1:    prot_o = (top_bits == 2'b11);
      2'd2:    prot_o = top_bits[1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_wp_policy.sv
module sr_wp_policy (
  input  logic wel,
  input  logic wpen,
  input  logic wp_pin,
  input  logic busy,
  output logic reg_ok,
  output logic array_ok
);
  logic idle_en;
  assign idle_en  = wel & ~busy;
  assign array_ok = idle_en;
  assign reg_ok   = idle_en & (~wpen | wp_pin);
endmodule

// File: rtl/sr_wr_timer.sv
module sr_wr_timer #(
  parameter int WR_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sr_core.sv
module sr_core #(
  parameter int ADDR_W    = 12,
  parameter int WR_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_pin,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wr_data,
  input  logic              cmd_rdsr,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_o,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              sr_wr_ok,
  output logic              addr_wr_ok
);
  import sr_pkg::*;

  logic       wel_q, wpen_q;
  logic [1:0] level_q;
  logic       busy, done;
  logic       reg_ok, array_ok, prot;
  logic       accept;
  sr_state_t  cur;
  logic       unused_bits;

  assign unused_bits = ^{wr_data[6:4], wr_data[1:0]};

  assign cur = '{wpen: wpen_q, level: level_q, wel: wel_q, busy: busy};
  assign status_o = sr_pack(cur);

  sr_wp_policy u_policy (
    .wel(wel_q), .wpen(wpen_q), .wp_pin(wp_pin), .busy(busy),
    .reg_ok(reg_ok), .array_ok(array_ok)
  );

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .level(level_q), .addr(chk_addr), .prot_o(prot)
  );

  assign accept = cmd_wrsr && reg_ok;

  sr_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(accept), .busy_o(busy), .done_o(done)
  );

  // latch and stored fields
  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q   <= 1'b0;
      wpen_q  <= 1'b0;
      level_q <= 2'd0;
    end else if (done) begin
      wel_q <= 1'b0;
    end else if (!busy) begin
      if (cmd_wrsr) begin
        if (accept) begin
          level_q <= wr_data[3:2];
          wpen_q  <= wr_data[7];
        end
      end else if (cmd_wrdi) begin
        wel_q <= 1'b0;
      end else if (cmd_wren) begin
        wel_q <= 1'b1;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      sr_wr_ok   <= 1'b0;
      addr_wr_ok <= 1'b0;
    end else begin
      rd_valid   <= cmd_rdsr;
      if (cmd_rdsr) rd_data <= status_o;
      sr_wr_ok   <= reg_ok;
      addr_wr_ok <= array_ok && !prot;
    end
  end
endmodule

// File: rtl/sr_core_chk.sv
module sr_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_pin,
  input logic       cmd_wrsr,
  input logic       cmd_rdsr,
  input logic [7:0] status_o,
  input logic       rd_valid,
  input logic       addr_wr_ok
);
  logic       busy, wel, wpen;
  logic [1:0] level;
  assign busy  = status_o[0];
  assign wel   = status_o[1];
  assign level = status_o[3:2];
  assign wpen  = status_o[7];

  AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> !wel); // R5
  AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> ($stable(level) && $stable(wpen))); // R6
  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst) (cmd_wrsr && !wel) |=> ($stable(level) && $stable(wpen) && !busy)); // R3
  AST_WPEN_LOCKED: assert property (@(posedge clk) disable iff (rst) (wpen && !wp_pin) |=> wpen); // R8
  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst) status_o[6:4] == 3'b000); // R4
  AST_FULL_PROTECT: assert property (@(posedge clk) disable iff (rst) (level == 2'd3) |=> !addr_wr_ok); // R9
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst) cmd_rdsr |=> rd_valid); // R6
  AST_NO_PERMIT_UNLATCHED: assert property (@(posedge clk) disable iff (rst) !wel |=> !addr_wr_ok); // R10
endmodule

bind sr_core sr_core_chk u_chk (
  .clk(clk), .rst(rst), .wp_pin(wp_pin), .cmd_wrsr(cmd_wrsr),
  .cmd_rdsr(cmd_rdsr), .status_o(status_o), .rd_valid(rd_valid),
  .addr_wr_ok(addr_wr_ok)
);

// File: tb/sim_sr_core.sv
`timescale 1ns/1ps
module sim_sr_core;
  localparam int AW = 12;
  localparam int WRC = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_pin = 1'b0, cmd_wren = 1'b0, cmd_wrdi = 1'b0;
  logic          cmd_wrsr = 1'b0, cmd_rdsr = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0]    status_o, rd_data;
  logic          rd_valid, sr_wr_ok, addr_wr_ok;

  always #4 clk = ~clk;

  sr_core #(.ADDR_W(AW), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .wp_pin(wp_pin), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wr_data(wr_data),
    .cmd_rdsr(cmd_rdsr), .chk_addr(chk_addr), .status_o(status_o),
    .rd_valid(rd_valid), .rd_data(rd_data), .sr_wr_ok(sr_wr_ok),
    .addr_wr_ok(addr_wr_ok)
  );

  int checks = 0, fails = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference
  int   m_cnt = 0;
  bit   m_wel = 0, m_wpen = 0;
  int   m_lvl = 0;
  bit   e_rdv = 0, e_sr = 0, e_addr = 0;
  int   e_rdd = 0;

  function automatic int m_status();
    return (m_wpen << 7) | (m_lvl << 2) | (m_wel << 1) | (m_cnt > 0 ? 1 : 0);
  endfunction

  function automatic bit m_prot(input int lvl, input logic [AW-1:0] a);
    if (lvl == 0) return 0;
    if (lvl == 1) return a[AW-1] && a[AW-2];
    if (lvl == 2) return a[AW-1];
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_wel = 0; m_wpen = 0; m_lvl = 0;
      e_rdv = 0; e_rdd = 0; e_sr = 0; e_addr = 0;
    end else begin
      bit busy, sr_ok;
      busy  = (m_cnt > 0);
      sr_ok = m_wel && !busy && (!m_wpen || wp_pin);
      e_sr   = sr_ok;
      e_addr = m_wel && !busy && !m_prot(m_lvl, chk_addr);
      e_rdv  = cmd_rdsr;
      if (cmd_rdsr) e_rdd = m_status();
      if (busy) begin
        m_cnt--;
        if (m_cnt == 0) m_wel = 0;
      end else if (cmd_wrsr) begin
        if (sr_ok) begin
          m_lvl  = int'(wr_data[3:2]);
          m_wpen = wr_data[7];
          m_cnt  = WRC;
        end
      end else if (cmd_wrdi) m_wel = 0;
      else if (cmd_wren) m_wel = 1;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk(status_o == 8'(m_status()), "R2 R4 R5 status", status_o, m_status());
      chk(rd_valid == e_rdv, "R6 rd_valid", rd_valid, e_rdv);
      if (e_rdv) chk(rd_data == 8'(e_rdd), "R6 rd_data", rd_data, e_rdd);
      chk(sr_wr_ok == e_sr, "R7 R8 sr_wr_ok", sr_wr_ok, e_sr);
      chk(addr_wr_ok == e_addr, "R9 R10 addr_wr_ok", addr_wr_ok, e_addr);
    end
  end

  task automatic step(input bit en, input bit dis, input bit wr, input logic [7:0] d,
                      input bit rd, input bit wp, input logic [AW-1:0] a);
    cmd_wren = en; cmd_wrdi = dis; cmd_wrsr = wr; wr_data = d;
    cmd_rdsr = rd; wp_pin = wp; chk_addr = a;
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_rdsr = 0;
  endtask

  task automatic idle(input int n, input bit wp);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, wp, '0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    chk(status_o == 8'h00, "R1 reset status", status_o, 0);
    chk(!sr_wr_ok && !addr_wr_ok, "R1 reset permissions", {sr_wr_ok, addr_wr_ok}, 0);
    // R3: write with latch clear is refused
    step(0, 0, 1, 8'h8C, 0, 1, '0);
    idle(1, 1);
    chk(status_o == 8'h00, "R3 refused write", status_o, 0);
    // R2: set then clear, priority of clear over set
    step(1, 0, 0, 8'h00, 0, 0, '0);
    chk(status_o == 8'h02, "R2 latch set", status_o, 8'h02);
    step(1, 1, 0, 8'h00, 0, 0, '0);
    chk(status_o == 8'h00, "R2 clear wins", status_o, 0);
    // R4 R5: accepted write, pin low, protect-enable clear
    step(1, 0, 0, 8'h00, 0, 0, '0);
    step(0, 0, 1, 8'hFF, 0, 0, '0);
    chk(status_o == 8'h8F, "R5 busy after write", status_o, 8'h8F);
    idle(WRC, 0);
    chk(status_o == 8'h8C, "R4 R5 fields loaded, latch cleared", status_o, 8'h8C);
    // R8: lock with pin low
    step(1, 0, 0, 8'h00, 0, 0, '0);
    step(0, 0, 1, 8'h00, 0, 0, '0);
    idle(2, 0);
    chk(status_o == 8'h8E, "R8 locked write refused", status_o, 8'h8E);
    // R7: pin high lifts the lock
    step(0, 0, 1, 8'h04, 1, 1, 12'hC00);
    idle(WRC + 1, 1);
    chk(status_o == 8'h04, "R7 write with pin high", status_o, 8'h04);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 20, r >= 20 && r < 25, r >= 25 && r < 45, 8'($urandom),
           $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0, AW'($urandom));
    end
    idle(WRC + 2, 1);
    finish_run();
  end
endmodule